// File: doc/BRIEF.md
# Embedded-Clock Frame Aligner and Deserializer

This block sits behind a clock/data recovery front end that hands it one recovered bit per clock enable. The serial stream is built from 12-bit frames. Each frame carries a 10-bit payload between two embedded clock bits: a 1 before the payload and a 0 after it. The block searches the stream for the frame boundary using only that fixed 1-to-0 pair. Once the boundary holds steady it raises `lock` and delivers each payload as a parallel word with a one-cycle strobe.

Alignment can come from a stream of sync frames (six ones then six zeros on the line) or from ordinary data. A sync frame helps the search but is never delivered as data. While `lock` is low the word output is held at zero and no strobe is issued. A powerdown input wipes all alignment state.

The control is a three-state machine:
- `ST_OFF` is the powered-down state.
- `ST_HUNT` tests one candidate boundary.
- `ST_LOCK` is the aligned state.

The transitions are:
- POWER_DOWN: from any state to `ST_OFF` while `pwr_down` is high.
- WAKE: `ST_OFF` to `ST_HUNT` once `pwr_down` falls.
- ACQUIRE: `ST_HUNT` to `ST_LOCK` after 4 good frames in a row.
- SLIP: `ST_HUNT` to itself on a bad frame. The good-frame count restarts and the boundary moves one bit later.
- MISS: `ST_LOCK` to itself on a single bad frame.
- LOSE: `ST_LOCK` to `ST_HUNT` on the second bad frame in a row.

Top module: `ecf_deser`

## Requirements
- R1: A frame is taken from 12 consecutive valid bits, first to last: embedded bit 1, payload bit 0 up to payload bit 9 (LSB first), embedded bit 0. While locked, each good frame puts its payload on `word_out`. `word_stb` pulses for one cycle; both appear after the clock edge that samples the frame's last bit.
- R2: After reset with the stream aligned, `lock` is still low after 3 good frames. It rises at the edge that samples the last bit of the 4th good frame. Those 4 frames produce no strobe.
- R3: A bad frame during the search restarts the good-frame count and moves the boundary one bit later. A sync-frame stream preceded by any number 0..11 of stray bits gives lock, and the next data frame is delivered correctly.
- R4: Lock is reached from plain data, with no sync frames, when every other frame has payload 0x000 and the stream starts at offsets 0, 5 or 11. The delivered words match the sent payloads.
- R5: A good frame with payload 0x01F (the line pattern 111111000000) is never strobed out, even while locked.
- R6: While locked, a single frame whose first bit is 0 or whose last bit is 1 keeps `lock` high and produces no strobe. Any good frame clears the miss count.
- R7: While locked, a second consecutive bad frame drops `lock` at the edge that samples its last bit. The search restarts at the same boundary, so 4 further aligned good frames relock.
- R8: Whenever `lock` is low, `word_out` is 0 and `word_stb` is 0.
- R9: Bits presented with `ser_valid` low are ignored.
- R10: `pwr_down` high is sampled synchronously. It clears `lock`, `word_out`, the bit window and the frame counters, and bits are ignored while it is high. After release, 4 aligned good frames are needed again.
- R11: `rst_n` low asynchronously clears `lock`, `word_out` and `word_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Powerdown; clears all alignment state |
| ser_bit | input | 1 | Recovered serial bit |
| ser_valid | input | 1 | Qualifies `ser_bit` for this cycle |
| word_out | output | 10 | Recovered payload word, zero while unlocked |
| word_stb | output | 1 | One-cycle strobe for a new word |
| lock | output | 1 | Frame alignment established |

## Verification
The bench sweeps every one of the 1024 payloads through a locked link, with idle cycles mixed in.
- A block that mis-ordered the payload bits or shifted the window by one would show up as word mismatches.
- A block that delivered the sync payload would show up as an unexpected strobe.

The acquisition is driven from all twelve starting offsets with sync frames, and from three offsets with plain data.
- A slip that moved the wrong way or by more than one bit would fail to lock.
- A slip that locked onto a false boundary would deliver corrupted words.

Lock timing is checked on an exact frame count after reset, after a loss of lock and after powerdown.
- A counter off by one would raise `lock` a frame early or late.
- A miss counter that was not cleared by good frames would drop lock on isolated errors.

// File: rtl/ecf_pkg.sv
package ecf_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HUNT = 2'd1,
        ST_LOCK = 2'd2
    } align_st_e;
endpackage

// File: rtl/ecf_window.sv
// Serial bit window: shifts in valid bits, counts bit positions within the
// candidate frame and flags each completed frame with its embedded-bit check.
module ecf_window #(
    parameter int PAY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             slip,
    output logic             frm_done,
    output logic             frm_good,
    output logic             frm_sync,
    output logic [PAY_W-1:0] frm_pay
);
    localparam int FRM_W = PAY_W + 2;
    localparam int CNT_W = $clog2(FRM_W) + 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRM_W - 1);
    localparam logic [PAY_W-1:0] SYNC_PAY = PAY_W'((1 << (FRM_W / 2 - 1)) - 1);

    logic [FRM_W-1:0] sr_q;
    logic [FRM_W-1:0] sr_nxt;
    logic [CNT_W-1:0] pos_q;
    logic             take;

    // Newest bit enters at the top, so after a full frame bit 0 is the first bit.
    assign sr_nxt   = {bit_in, sr_q[FRM_W-1:1]};
    assign take     = bit_vld && !clr;
    assign frm_done = take && (pos_q == LAST_POS);
    assign frm_pay  = sr_nxt[FRM_W-2:1];
    assign frm_good = sr_nxt[0] && !sr_nxt[FRM_W-1];
    assign frm_sync = frm_good && (frm_pay == SYNC_PAY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            pos_q <= '0;
        end else if (clr) begin
            sr_q  <= '0;
            pos_q <= '0;
        end else if (take) begin
            sr_q <= sr_nxt;
            if (pos_q == LAST_POS) begin
                // All-ones wraps to zero on the next bit: one extra bit of wait.
                pos_q <= slip ? '1 : '0;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q <= LAST_POS) || (pos_q == '1));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_vld && !clr) |=> $stable(pos_q) && $stable(sr_q));
endmodule

// File: rtl/ecf_align_fsm.sv
// Alignment control: hunts for a boundary, confirms it, and watches for loss.
module ecf_align_fsm
    import ecf_pkg::*;
#(
    parameter int ACQ_FRAMES  = 4,
    parameter int LOSS_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down,
    input  logic frm_done,
    input  logic frm_good,
    input  logic frm_sync,
    output logic slip,
    output logic emit,
    output logic drop,
    output logic locked
);
    localparam int ACQ_W  = $clog2(ACQ_FRAMES + 1);
    localparam int MISS_W = $clog2(LOSS_FRAMES + 1);
    localparam logic [ACQ_W-1:0]  ACQ_LAST  = ACQ_W'(ACQ_FRAMES - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOSS_FRAMES - 1);

    align_st_e         state_q, state_d;
    logic [ACQ_W-1:0]  acq_q, acq_d;
    logic [MISS_W-1:0] miss_q, miss_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            acq_q   <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            acq_q   <= acq_d;
            miss_q  <= miss_d;
        end
    end

    always_comb begin
        state_d = state_q;
        acq_d   = acq_q;
        miss_d  = miss_q;
        if (pwr_down) begin
            // POWER_DOWN
            state_d = ST_OFF;
            acq_d   = '0;
            miss_d  = '0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    // WAKE
                    state_d = ST_HUNT;
                end
                ST_HUNT: begin
                    if (frm_done) begin
                        if (!frm_good) begin
                            // SLIP
                            acq_d = '0;
                        end else if (acq_q == ACQ_LAST) begin
                            // ACQUIRE
                            state_d = ST_LOCK;
                            acq_d   = '0;
                            miss_d  = '0;
                        end else begin
                            acq_d = acq_q + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (frm_done) begin
                        if (frm_good) begin
                            miss_d = '0;
                        end else if (miss_q == MISS_LAST) begin
                            // LOSE
                            state_d = ST_HUNT;
                            miss_d  = '0;
                            acq_d   = '0;
                        end else begin
                            // MISS
                            miss_d = miss_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_HUNT;
                end
            endcase
        end
    end

    always_comb begin
        locked = (state_q == ST_LOCK);
        slip   = (state_q == ST_HUNT) && frm_done && !frm_good;
        emit   = (state_q == ST_LOCK) && frm_done && frm_good && !frm_sync;
        drop   = (state_q == ST_LOCK) && (state_d != ST_LOCK);
    end

    // R2
    lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(frm_done && frm_good));

    // R7
    lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(pwr_down || (frm_done && !frm_good)));

    // R10
    pdn_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !locked);
endmodule

// File: rtl/ecf_word_out.sv
// Parallel output register: loads delivered payloads, zeroes on loss of lock.
module ecf_word_out #(
    parameter int PAY_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit,
    input  logic             drop,
    input  logic [PAY_W-1:0] pay_in,
    output logic [PAY_W-1:0] word_q,
    output logic             stb_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= emit;
            if (drop) begin
                word_q <= '0;
            end else if (emit) begin
                word_q <= pay_in;
            end
        end
    end
endmodule

// File: rtl/ecf_deser.sv
module ecf_deser #(
    parameter int PAY_W       = 10,
    parameter int ACQ_FRAMES  = 4,
    parameter int LOSS_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down,
    input  logic             ser_bit,
    input  logic             ser_valid,
    output logic [PAY_W-1:0] word_out,
    output logic             word_stb,
    output logic             lock
);
    logic             frm_done;
    logic             frm_good;
    logic             frm_sync;
    logic [PAY_W-1:0] frm_pay;
    logic             slip;
    logic             emit;
    logic             drop;

    ecf_window #(.PAY_W(PAY_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pwr_down),
        .bit_in   (ser_bit),
        .bit_vld  (ser_valid),
        .slip     (slip),
        .frm_done (frm_done),
        .frm_good (frm_good),
        .frm_sync (frm_sync),
        .frm_pay  (frm_pay)
    );

    ecf_align_fsm #(.ACQ_FRAMES(ACQ_FRAMES), .LOSS_FRAMES(LOSS_FRAMES)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_down (pwr_down),
        .frm_done (frm_done),
        .frm_good (frm_good),
        .frm_sync (frm_sync),
        .slip     (slip),
        .emit     (emit),
        .drop     (drop),
        .locked   (lock)
    );

    ecf_word_out #(.PAY_W(PAY_W)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .emit   (emit),
        .drop   (drop),
        .pay_in (frm_pay),
        .word_q (word_out),
        .stb_q  (word_stb)
    );

    // R8
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock |-> (word_out == '0) && !word_stb);

    // R1
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);
endmodule

// File: tb/test_ecf_deser.sv
module test_ecf_deser;
    localparam int CLK_PERIOD = 10;
    localparam int PAY_W      = 10;
    localparam logic [PAY_W-1:0] SYNC_W = 10'h01F;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pwr_down = 1'b0;
    logic             ser_bit = 1'b0;
    logic             ser_valid = 1'b0;
    logic [PAY_W-1:0] word_out;
    logic             word_stb;
    logic             lock;

    int checks = 0;
    int fails = 0;
    int stb_seen = 0;
    int idle_viol = 0;
    logic [PAY_W-1:0] exp_q[$];
    logic [PAY_W-1:0] exp_w;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ecf_deser i_ecf_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_down  (pwr_down),
        .ser_bit   (ser_bit),
        .ser_valid (ser_valid),
        .word_out  (word_out),
        .word_stb  (word_stb),
        .lock      (lock)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Strobe monitor (R1, R5) and idle-output watch (R8)
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_stb) begin
                stb_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected strobe", int'(word_out), 0);
                end else begin
                    exp_w = exp_q.pop_front();
                    chk(word_out == exp_w, "R1 delivered word", int'(word_out), int'(exp_w));
                end
            end
            if (!lock && (word_out != '0 || word_stb)) idle_viol++;
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_bit   = b;
        ser_valid = 1'b1;
    endtask

    task automatic send_frame(input logic [PAY_W-1:0] pay, input logic st = 1'b1,
                              input logic sp = 1'b0);
        logic lk;
        lk = 1'b0;
        for (int i = 0; i < PAY_W + 2; i++) begin
            @(negedge clk);
            if (i == 0) lk = lock;
            ser_bit   = (i == 0) ? st : (i == PAY_W + 1) ? sp : pay[i-1];
            ser_valid = 1'b1;
        end
        if (lk && st && !sp && pay != SYNC_W) exp_q.push_back(pay);
    endtask

    task automatic gap;
        @(negedge clk);
        ser_valid = 1'b0;
        ser_bit   = ~ser_bit;
    endtask

    task automatic settle;
        @(negedge clk);
        ser_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n     = 1'b0;
        ser_valid = 1'b0;
        pwr_down  = 1'b0;
        exp_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int s0;
        int n;
        // R11 reset state
        repeat (2) @(negedge clk);
        chk(lock == 1'b0, "R11 lock in reset", int'(lock), 0);
        chk(word_out == '0, "R11 word in reset", int'(word_out), 0);
        chk(word_stb == 1'b0, "R11 strobe in reset", int'(word_stb), 0);
        rst_n = 1'b1;

        // R2 exact acquisition time
        send_frame(10'h155);
        send_frame(10'h2AA);
        send_frame(10'h0F0);
        settle();
        chk(lock == 1'b0, "R2 lock after 3 frames", int'(lock), 0);
        send_frame(10'h333);
        settle();
        chk(lock == 1'b1, "R2 lock after 4 frames", int'(lock), 1);
        chk(stb_seen == 0, "R2 no strobe during acquisition", stb_seen, 0);

        // R1/R5/R9 exhaustive payload sweep with idle gaps
        s0 = stb_seen;
        for (int v = 0; v < 1024; v++) begin
            send_frame(PAY_W'(v));
            if (v % 97 == 0) begin
                gap();
                gap();
            end
        end
        settle();
        chk(exp_q.size() == 0, "R1 all words delivered", exp_q.size(), 0);
        chk(stb_seen - s0 == 1023, "R5 sync payload withheld", stb_seen - s0, 1023);
        chk(lock == 1'b1, "R9 lock kept across idle gaps", int'(lock), 1);

        // R6 isolated errors while locked
        s0 = stb_seen;
        send_frame(10'h123, 1'b0, 1'b0);
        settle();
        chk(lock == 1'b1, "R6 lock after one bad frame", int'(lock), 1);
        send_frame(10'h0AB);
        send_frame(10'h111, 1'b1, 1'b1);
        settle();
        chk(lock == 1'b1, "R6 miss count cleared by good frame", int'(lock), 1);
        send_frame(10'h3C3);
        settle();
        chk(stb_seen - s0 == 2, "R6 bad frames not strobed", stb_seen - s0, 2);

        // R7 loss of lock and relock at same boundary
        send_frame(10'h0FF, 1'b0, 1'b0);
        send_frame(10'h0FF, 1'b1, 1'b1);
        settle();
        chk(lock == 1'b0, "R7 lock dropped", int'(lock), 0);
        chk(word_out == '0, "R8 word zero after drop", int'(word_out), 0);
        send_frame(10'h001);
        send_frame(10'h002);
        send_frame(10'h004);
        settle();
        chk(lock == 1'b0, "R7 no relock after 3", int'(lock), 0);
        send_frame(10'h008);
        settle();
        chk(lock == 1'b1, "R7 relock after 4", int'(lock), 1);
        send_frame(10'h2D2);
        settle();

        // R10 powerdown mid-frame
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        @(negedge clk);
        pwr_down = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            ser_valid = 1'b1;
            ser_bit   = ~ser_bit;
        end
        chk(lock == 1'b0, "R10 lock cleared", int'(lock), 0);
        chk(word_out == '0, "R10 word cleared", int'(word_out), 0);
        @(negedge clk);
        pwr_down  = 1'b0;
        ser_valid = 1'b0;
        send_frame(10'h111);
        send_frame(10'h222);
        send_frame(10'h044);
        settle();
        chk(lock == 1'b0, "R10 no lock after 3", int'(lock), 0);
        send_frame(10'h088);
        settle();
        chk(lock == 1'b1, "R10 relock after 4", int'(lock), 1);

        // R3 sync-pattern acquisition from every bit offset
        for (int off = 0; off < 12; off++) begin
            do_reset();
            for (int b = 0; b < off; b++) send_bit(1'b1);
            n = 0;
            while (!lock && n < 24) begin
                send_frame(SYNC_W);
                settle();
                n++;
            end
            chk(lock == 1'b1 && n <= 20, "R3 lock from sync stream", n, 20);
            s0 = stb_seen;
            send_frame(10'h2C5);
            settle();
            chk(stb_seen - s0 == 1, "R3 data after sync lock", stb_seen - s0, 1);
        end

        // R4 acquisition from data alone
        for (int k = 0; k < 3; k++) begin
            int off;
            off = (k == 0) ? 0 : (k == 1) ? 5 : 11;
            do_reset();
            for (int b = 0; b < off; b++) send_bit(1'b0);
            s0 = stb_seen;
            for (int i = 0; i < 40; i++) begin
                send_frame((i % 2 == 0) ? 10'h000 : PAY_W'((i * 37 + 5) & 10'h3FF));
            end
            settle();
            chk(lock == 1'b1, "R4 lock from data", int'(lock), 1);
            chk(stb_seen > s0, "R4 words delivered", stb_seen - s0, 1);
            chk(exp_q.size() == 0, "R4 queue drained", exp_q.size(), 0);
        end

        chk(idle_viol == 0, "R8 outputs quiet while unlocked", idle_viol, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule